// File: doc/BRIEF.md
# User I/O and Debug Pin Controller

This block gives two independent register ports a common view of a board's user I/O. Push-button and switch inputs are synchronised and then debounced against a slow tick, so a level only counts once it has stayed put for a programmable number of millisecond ticks. The debounced levels are copied into an input register on every clock. Any change of an input whose interrupt enable bit is set latches a status bit and raises one interrupt line. Software clears each status bit by writing a 1 to it.

LED levels come straight from a software register. A 16-pin debug header is configured pin by pin through three registers:
- a direction register, which selects input or output;
- a source register, which selects between a hardware status vector and a software GPIO register for each output pin;
- the GPIO register itself.

A readback register reports the level of every pin. Both ports reach the same registers. If both ports write one register in the same cycle, port 0 wins. The block provides no locking between the ports.

Top module: `usrio_ctrl`

## Requirements
- R1: A debounced input changes only after its synchronised raw level has differed from it on `limit` consecutive ticks, with one tick every TICK_DIV clocks. Any return to the debounced level clears the count, so shorter pulses are ignored. A limit of 0 acts like 1.
- R2: The debounce limit register is at address 8 (8 bits). It resets to 20 and is writable.
- R3: Address 0 reads the debounced inputs in bits [NUM_IN-1:0]. The value is refreshed every clock and is the same from both ports.
- R4: Address 2 holds the per-input interrupt enables (1 = enabled). A debounced change of an enabled input sets the matching bit of the status register at address 1. A change of a disabled input does not set it. `irq` is high exactly when any status bit is set.
- R5: Writing to the status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R6: The LED register is at address 3. It drives `ledOut` from the clock edge of the write and reads back.
- R7: When both ports write the same address in one cycle, port 0's data is stored. Writes by the two ports to different addresses in one cycle both take effect.
- R8: The direction register is at address 4 (1 = output). `dbgOe` equals it.
- R9: The source register is at address 5 (1 = hardware). A hardware-sourced pin drives `dbgOut` from the matching `dbgHwIn` bit. A software-sourced pin drives it from the GPIO register at address 6.
- R10: Address 7 reads each output pin's driven level and each input pin's `dbgIn` level.
- R11: After reset, `irq`, `ledOut` and `dbgOe` are 0, every register reads 0, and the limit register reads 20.
- R12: Addresses 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | NUM_IN | Raw button/switch levels |
| ledOut | output | NUM_LED | LED drive |
| dbgHwIn | input | NUM_DBG | Hardware status vector for debug pins |
| dbgIn | input | NUM_DBG | Sensed debug pin levels |
| dbgOut | output | NUM_DBG | Debug pin drive values |
| dbgOe | output | NUM_DBG | Debug pin output enables |
| irq | output | 1 | Interrupt |
| p0Wr | input | 1 | Port 0 write strobe |
| p0Addr | input | 4 | Port 0 word address |
| p0Wdata | input | 32 | Port 0 write data |
| p0Rdata | output | 32 | Port 0 read data (combinational) |
| p1Wr | input | 1 | Port 1 write strobe |
| p1Addr | input | 4 | Port 1 word address |
| p1Wdata | input | 32 | Port 1 write data |
| p1Rdata | output | 32 | Port 1 read data (combinational) |

## Verification
On every cycle the assertions check the following:
- LED updates, including the priority of port 0.
- LEDs and pin directions staying put when their registers are not written.
- Debounced levels moving only on a tick.
- The input register trailing the debounced value by one clock.
- Each rise of `irq` being preceded by a debounced change.

Only the bench's scenarios can show that short pulses are rejected and held levels accepted after `limit` ticks. The same holds for masked inputs leaving status clear, the write-one-to-clear behaviour, the pin source and readback mixing, and unmapped addresses reading zero.

// File: rtl/usrio_pkg.sv
package usrio_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int NREG   = 9;
  localparam int CNT_W  = 8;
  localparam logic [CNT_W-1:0] LIMIT_RST = 8'd20;

  localparam int A_INPUT = 0;
  localparam int A_STAT  = 1;
  localparam int A_EN    = 2;
  localparam int A_LED   = 3;
  localparam int A_DIR   = 4;
  localparam int A_SRC   = 5;
  localparam int A_GPIO  = 6;
  localparam int A_PINS  = 7;
  localparam int A_LIMIT = 8;

  typedef struct packed {
    logic [NREG-1:0]             we;
    logic [NREG-1:0][DATA_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/usrio_debounce.sv
module usrio_debounce #(
  parameter int NUM_IN   = 8,
  parameter int TICK_DIV = 100000,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] rawIn,
  input  logic [CNT_W-1:0]  limit,
  output logic [NUM_IN-1:0] debVal,
  output logic              tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] tickCnt;
  logic [NUM_IN-1:0] syncA, syncB;

  assign tick = (tickCnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      syncA   <= rawIn;
      syncB   <= syncA;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cntInc;
    assign cntInc = {1'b0, cnt} + 1'b1;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt       <= '0;
        debVal[i] <= 1'b0;
      end else if (syncB[i] == debVal[i]) begin
        cnt <= '0;
      end else if (tick) begin
        if (cntInc >= {1'b0, limit}) begin
          debVal[i] <= syncB[i];
          cnt       <= '0;
        end else begin
          cnt <= cntInc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/usrio_regctl.sv
module usrio_regctl
  import usrio_pkg::*;
(
  input  logic              p0Wr,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic [DATA_W-1:0] p0Wdata,
  input  logic              p1Wr,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic [DATA_W-1:0] p1Wdata,
  output wrStrobe_t         strobe
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit0, hit1;
    assign hit0 = p0Wr && (p0Addr == ADDR_W'(r));
    assign hit1 = p1Wr && (p1Addr == ADDR_W'(r));
    assign strobe.we[r]   = hit0 || hit1;
    assign strobe.data[r] = hit0 ? p0Wdata : p1Wdata;
  end
endmodule

// File: rtl/usrio_regs.sv
module usrio_regs
  import usrio_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_LED = 8,
  parameter int NUM_DBG = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  logic [NUM_IN-1:0]  debVal,
  input  logic [NUM_DBG-1:0] dbgHwIn,
  input  logic [NUM_DBG-1:0] dbgIn,
  input  logic [ADDR_W-1:0]  p0Addr,
  input  logic [ADDR_W-1:0]  p1Addr,
  output logic [DATA_W-1:0]  p0Rdata,
  output logic [DATA_W-1:0]  p1Rdata,
  output logic [CNT_W-1:0]   limit,
  output logic [NUM_LED-1:0] ledOut,
  output logic [NUM_DBG-1:0] dbgOut,
  output logic [NUM_DBG-1:0] dbgOe,
  output logic               irq
);
  logic [NUM_IN-1:0]  inReg, debPrev, status, intEn;
  logic [NUM_DBG-1:0] dirReg, srcReg, gpioReg, pinState;

  assign dbgOut   = (srcReg & dbgHwIn) | (~srcReg & gpioReg);
  assign dbgOe    = dirReg;
  assign pinState = (dirReg & dbgOut) | (~dirReg & dbgIn);
  assign irq      = |status;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg   <= '0;
      debPrev <= '0;
      status  <= '0;
      intEn   <= '0;
      ledOut  <= '0;
      dirReg  <= '0;
      srcReg  <= '0;
      gpioReg <= '0;
      limit   <= LIMIT_RST;
    end else begin
      inReg   <= debVal;
      debPrev <= debVal;
      status  <= (status & ~(strobe.we[A_STAT] ? strobe.data[A_STAT][NUM_IN-1:0] : '0))
               | ((debVal ^ debPrev) & intEn);
      if (strobe.we[A_EN])    intEn   <= strobe.data[A_EN][NUM_IN-1:0];
      if (strobe.we[A_LED])   ledOut  <= strobe.data[A_LED][NUM_LED-1:0];
      if (strobe.we[A_DIR])   dirReg  <= strobe.data[A_DIR][NUM_DBG-1:0];
      if (strobe.we[A_SRC])   srcReg  <= strobe.data[A_SRC][NUM_DBG-1:0];
      if (strobe.we[A_GPIO])  gpioReg <= strobe.data[A_GPIO][NUM_DBG-1:0];
      if (strobe.we[A_LIMIT]) limit   <= strobe.data[A_LIMIT][CNT_W-1:0];
    end
  end

  function automatic logic [DATA_W-1:0] readMux(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v;
    v = '0;
    case (int'(a))
      A_INPUT: v[NUM_IN-1:0]  = inReg;
      A_STAT:  v[NUM_IN-1:0]  = status;
      A_EN:    v[NUM_IN-1:0]  = intEn;
      A_LED:   v[NUM_LED-1:0] = ledOut;
      A_DIR:   v[NUM_DBG-1:0] = dirReg;
      A_SRC:   v[NUM_DBG-1:0] = srcReg;
      A_GPIO:  v[NUM_DBG-1:0] = gpioReg;
      A_PINS:  v[NUM_DBG-1:0] = pinState;
      A_LIMIT: v[CNT_W-1:0]   = limit;
      default: v = '0;
    endcase
    return v;
  endfunction

  assign p0Rdata = readMux(p0Addr);
  assign p1Rdata = readMux(p1Addr);
endmodule

// File: rtl/usrio_ctrl.sv
module usrio_ctrl
  import usrio_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_LED  = 8,
  parameter int NUM_DBG  = 16,
  parameter int TICK_DIV = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  rawIn,
  output logic [NUM_LED-1:0] ledOut,
  input  logic [NUM_DBG-1:0] dbgHwIn,
  input  logic [NUM_DBG-1:0] dbgIn,
  output logic [NUM_DBG-1:0] dbgOut,
  output logic [NUM_DBG-1:0] dbgOe,
  output logic               irq,
  input  logic               p0Wr,
  input  logic [3:0]         p0Addr,
  input  logic [31:0]        p0Wdata,
  output logic [31:0]        p0Rdata,
  input  logic               p1Wr,
  input  logic [3:0]         p1Addr,
  input  logic [31:0]        p1Wdata,
  output logic [31:0]        p1Rdata
);
  wrStrobe_t         strobe;
  logic [NUM_IN-1:0] debVal;
  logic              tick;
  logic [CNT_W-1:0]  limit;

  usrio_debounce #(.NUM_IN(NUM_IN), .TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) deb_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .limit(limit),
    .debVal(debVal), .tick(tick));

  usrio_regctl ctl_i (
    .p0Wr(p0Wr), .p0Addr(p0Addr), .p0Wdata(p0Wdata),
    .p1Wr(p1Wr), .p1Addr(p1Addr), .p1Wdata(p1Wdata),
    .strobe(strobe));

  usrio_regs #(.NUM_IN(NUM_IN), .NUM_LED(NUM_LED), .NUM_DBG(NUM_DBG)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .debVal(debVal),
    .dbgHwIn(dbgHwIn), .dbgIn(dbgIn), .p0Addr(p0Addr), .p1Addr(p1Addr),
    .p0Rdata(p0Rdata), .p1Rdata(p1Rdata), .limit(limit),
    .ledOut(ledOut), .dbgOut(dbgOut), .dbgOe(dbgOe), .irq(irq));
endmodule

// File: rtl/usrio_ctrl_chk.sv
module usrio_ctrl_chk #(
  parameter int NUM_IN  = 8,
  parameter int NUM_LED = 8,
  parameter int NUM_DBG = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               irq,
  input logic [NUM_LED-1:0] ledOut,
  input logic [NUM_DBG-1:0] dbgOe,
  input logic               p0Wr,
  input logic [3:0]         p0Addr,
  input logic [31:0]        p0Wdata,
  input logic [31:0]        p0Rdata,
  input logic               p1Wr,
  input logic [3:0]         p1Addr,
  input logic [31:0]        p1Wdata,
  input logic [NUM_IN-1:0]  debVal,
  input logic               tick
);
  logic p0Led, p1Led, p0Dir, p1Dir;
  assign p0Led = p0Wr && (p0Addr == 4'd3);
  assign p1Led = p1Wr && (p1Addr == 4'd3);
  assign p0Dir = p0Wr && (p0Addr == 4'd4);
  assign p1Dir = p1Wr && (p1Addr == 4'd4);

  assert_led_port0_R7: assert property (@(posedge clk) disable iff (!rstN)
    p0Led |=> ledOut == $past(p0Wdata[NUM_LED-1:0]));

  assert_led_port1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (p1Led && !p0Led) |=> ledOut == $past(p1Wdata[NUM_LED-1:0]));

  assert_led_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!p0Led && !p1Led) |=> $stable(ledOut));

  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!p0Dir && !p1Dir) |=> $stable(dbgOe));

  assert_deb_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (debVal != $past(debVal)) |-> $past(tick));

  assert_input_reg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (p0Addr == 4'd0) |-> p0Rdata[NUM_IN-1:0] == $past(debVal));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(debVal) != $past(debVal, 2));
endmodule

bind usrio_ctrl usrio_ctrl_chk #(.NUM_IN(NUM_IN), .NUM_LED(NUM_LED), .NUM_DBG(NUM_DBG)) chk_i (
  .clk(clk), .rstN(rstN), .irq(irq), .ledOut(ledOut), .dbgOe(dbgOe),
  .p0Wr(p0Wr), .p0Addr(p0Addr), .p0Wdata(p0Wdata), .p0Rdata(p0Rdata),
  .p1Wr(p1Wr), .p1Addr(p1Addr), .p1Wdata(p1Wdata),
  .debVal(debVal), .tick(tick));

// File: tb/usrio_ctrl_tb.sv
module usrio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rawIn = '0;
  logic [7:0]  ledOut;
  logic [15:0] dbgHwIn = '0, dbgIn = '0, dbgOut, dbgOe;
  logic        irq;
  logic        p0Wr = 1'b0, p1Wr = 1'b0;
  logic [3:0]  p0Addr = '0, p1Addr = '0;
  logic [31:0] p0Wdata = '0, p1Wdata = '0, p0Rdata, p1Rdata;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usrio_ctrl #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ledOut(ledOut),
    .dbgHwIn(dbgHwIn), .dbgIn(dbgIn), .dbgOut(dbgOut), .dbgOe(dbgOe), .irq(irq),
    .p0Wr(p0Wr), .p0Addr(p0Addr), .p0Wdata(p0Wdata), .p0Rdata(p0Rdata),
    .p1Wr(p1Wr), .p1Addr(p1Addr), .p1Wdata(p1Wdata), .p1Rdata(p1Rdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit use0, input bit use1, input logic [3:0] a0, input logic [31:0] d0,
                    input logic [3:0] a1, input logic [31:0] d1);
    @(negedge clk);
    p0Wr = use0; p0Addr = a0; p0Wdata = d0;
    p1Wr = use1; p1Addr = a1; p1Wdata = d1;
    @(negedge clk);
    p0Wr = 1'b0; p1Wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    p0Addr = a; p1Addr = a;
    #1 d = p0Rdata;
    if (p1Rdata !== p0Rdata) check("R3 port1 readback", p1Rdata, p0Rdata);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset;
    logic [31:0] d;
    check("R11 irq", {31'd0, irq}, 32'd0);
    check("R11 ledOut", {24'd0, ledOut}, 32'd0);
    check("R11 dbgOe", {16'd0, dbgOe}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      if (a != 7) check("R11 register zero", d, 32'd0);
    end
    rd(4'd8, d);
    check("R2 limit default", d, 32'd20);
  endtask

  task automatic testLed;
    logic [31:0] d;
    wr(1, 0, 4'd3, 32'h5A, 4'd0, 0);
    check("R6 ledOut port0", {24'd0, ledOut}, 32'h5A);
    wr(0, 1, 4'd0, 0, 4'd3, 32'hC3);
    rd(4'd3, d);
    check("R6 led readback port1", d, 32'hC3);
  endtask

  task automatic testCollision;
    logic [31:0] d;
    wr(1, 1, 4'd3, 32'h11, 4'd3, 32'h22);
    check("R7 same address port0 wins", {24'd0, ledOut}, 32'h11);
    wr(1, 1, 4'd3, 32'h33, 4'd6, 32'h0F0F);
    check("R7 different address port0", {24'd0, ledOut}, 32'h33);
    rd(4'd6, d);
    check("R7 different address port1", d, 32'h0F0F);
  endtask

  task automatic testDebug;
    logic [31:0] d;
    logic [15:0] dir = 16'h00FF, src = 16'h000F, gpio = 16'h00A5, drv;
    dbgHwIn = 16'h1234; dbgIn = 16'hBEEF;
    wr(1, 1, 4'd4, dir, 4'd5, src);
    wr(1, 0, 4'd6, gpio, 4'd0, 0);
    drv = (src & dbgHwIn) | (~src & gpio);
    check("R8 dbgOe", {16'd0, dbgOe}, {16'd0, dir});
    check("R9 driven outputs", {16'd0, dbgOut & dir}, {16'd0, drv & dir});
    rd(4'd7, d);
    check("R10 pin readback", d, {16'd0, (dir & drv) | (~dir & dbgIn)});
    dbgHwIn = 16'h00F0;
    #1 check("R9 hw source follows", {28'd0, dbgOut[3:0]}, 32'h0);
  endtask

  task automatic testDebounce;
    logic [31:0] d;
    wr(0, 1, 4'd0, 0, 4'd8, 32'd3);
    wr(1, 0, 4'd2, 32'hFF, 4'd0, 0);
    rawIn = 8'h01;
    waitCycles(6);
    rd(4'd0, d);
    check("R1 not before limit ticks", d, 32'h00);
    waitCycles(30);
    rd(4'd0, d);
    check("R1 held level accepted", d, 32'h01);
    rd(4'd1, d);
    check("R4 status set", d, 32'h01);
    check("R4 irq high", {31'd0, irq}, 32'd1);
    wr(1, 0, 4'd1, 32'h00, 4'd0, 0);
    rd(4'd1, d);
    check("R5 zero write keeps status", d, 32'h01);
    wr(0, 1, 4'd0, 0, 4'd1, 32'h01);
    rd(4'd1, d);
    check("R5 one write clears", d, 32'h00);
    check("R4 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic testGlitch;
    logic [31:0] d;
    rawIn = 8'h03;
    waitCycles(6);
    rawIn = 8'h01;
    waitCycles(40);
    rd(4'd0, d);
    check("R1 short pulse ignored", d, 32'h01);
    rd(4'd1, d);
    check("R1 no status from pulse", d, 32'h00);
  endtask

  task automatic testMask;
    logic [31:0] d;
    wr(1, 0, 4'd2, 32'h01, 4'd0, 0);
    rawIn = 8'h05;
    waitCycles(40);
    rd(4'd0, d);
    check("R3 masked input still captured", d, 32'h05);
    rd(4'd1, d);
    check("R4 disabled input no status", d, 32'h00);
    check("R4 disabled input no irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic testLimitZero;
    logic [31:0] d;
    wr(1, 0, 4'd8, 32'd0, 4'd0, 0);
    rawIn = 8'h04;
    waitCycles(10);
    rd(4'd0, d);
    check("R1 limit zero acts as one", d, 32'h04);
    rd(4'd8, d);
    check("R2 limit writable", d, 32'd0);
  endtask

  task automatic testUnmapped;
    logic [31:0] d;
    wr(1, 1, 4'd12, 32'hFFFF_FFFF, 4'd9, 32'hFFFF_FFFF);
    rd(4'd12, d);
    check("R12 unmapped reads zero", d, 32'h0);
    rd(4'd9, d);
    check("R12 unmapped 9 reads zero", d, 32'h0);
    check("R12 led untouched", {24'd0, ledOut}, 32'h33);
    check("R12 dir untouched", {16'd0, dbgOe}, 32'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testLed;
    testCollision;
    testDebug;
    testDebounce;
    testGlitch;
    testMask;
    testLimitZero;
    testUnmapped;
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule